// File: doc/BRIEF.md
# DMA Width-Adapting Packer/Unpacker

This block is the data path of one DMA stream placed between a peripheral-side port and a memory-side port. When the two ports have different data widths it gathers narrow source items into one wide destination word, or splits one wide source word into several narrow destination items. Byte lanes are placed little-endian. It also produces the incrementing address on each side. The direction bit selects which side is read and which is written. The item count is always given in peripheral-side items.

Software-facing logic outside the block loads the widths, the count, the direction, the address-step mode and the two base addresses, then pulses `start`. The block then works in chunks. A chunk is one word of the wider port. The block issues the source reads for that chunk, then the destination writes for it, over simple valid/ready channels. Read data is taken in the cycle where valid and ready are both high. When the last destination write is accepted the block pulses `done`. If the programmed values are illegal, the block raises `cfg_err` and moves no data.

Top module: `dma_width_adapter`

## Requirements
- R1: Each port width is chosen on its own by a 2-bit code: 0 = 8 bits, 1 = 16 bits, 2 = 32 bits. All nine combinations work in both directions (`cfg_dir` 0 = peripheral to memory, 1 = memory to peripheral). Code 3 on either side is a configuration error.
- R2: The count is in peripheral items. A run makes exactly `count` peripheral accesses and `count*Pbytes/Mbytes` memory accesses, and never drives a channel of the wrong side.
- R3: Packing is little-endian. The first narrow item lands in the lowest lanes of the wide word, and later items fill successively higher lanes.
- R4: Unpacking emits the lowest lanes of a wide word first. Each narrow item appears in the low bits of the write data, with the upper bits zero.
- R5: With `cfg_pstep4` = 0, the peripheral address starts at `cfg_paddr` and advances by the peripheral item size (1, 2 or 4 bytes) after each peripheral access.
- R6: With `cfg_pstep4` = 1, the peripheral address advances by 4 after each item, whatever the peripheral width.
- R7: The memory address starts at `cfg_maddr` and advances by the memory item size after each memory access.
- R8: A start with a zero count, a size code of 3, or a count that is not a multiple of Mbytes/Pbytes (when the peripheral side is narrower) sets `cfg_err` and issues no request and no `done`. `cfg_err` holds until a legal start clears it.
- R9: A request that is not accepted keeps its valid, address and write data unchanged until ready is seen.
- R10: `done` is high for exactly one cycle. That cycle directly follows the clock edge that accepts the final destination write.
- R11: The asynchronous active-low reset clears `done`, `cfg_err`, every valid output and the internal counters.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a run (taken only when idle) |
| cfg_dir | input | 1 | 0: peripheral to memory, 1: memory to peripheral |
| cfg_psize | input | 2 | Peripheral width code |
| cfg_msize | input | 2 | Memory width code |
| cfg_count | input | 16 | Number of peripheral items |
| cfg_pstep4 | input | 1 | Fixed 4-byte peripheral address step |
| cfg_paddr | input | 32 | Peripheral base address |
| cfg_maddr | input | 32 | Memory base address |
| p_addr | output | 32 | Peripheral request address |
| p_rd_valid | output | 1 | Peripheral read request |
| p_rd_ready | input | 1 | Peripheral read accepted, data valid |
| p_rd_data | input | 32 | Peripheral read data |
| p_wr_valid | output | 1 | Peripheral write request |
| p_wr_ready | input | 1 | Peripheral write accepted |
| p_wr_data | output | 32 | Peripheral write data |
| m_addr | output | 32 | Memory request address |
| m_rd_valid | output | 1 | Memory read request |
| m_rd_ready | input | 1 | Memory read accepted, data valid |
| m_rd_data | input | 32 | Memory read data |
| m_wr_valid | output | 1 | Memory write request |
| m_wr_ready | input | 1 | Memory write accepted |
| m_wr_data | output | 32 | Memory write data |
| done | output | 1 | One-cycle end-of-run pulse |
| cfg_err | output | 1 | Illegal configuration seen at start |

## Verification
The assertions check four things on every cycle. A stalled request keeps its address and data. `done` lasts one cycle, follows a write acceptance and arrives with the item counter at zero. An error state issues no request. A lane write never reaches past the top of the packing word. Lane order, the address sequences for each width pair and step mode, the access counts, and the error and recovery rules come only from the bench scenarios. In these scenarios, directed and random widths, counts and ready patterns are compared against byte streams that the bench rebuilds from the source addresses.

// File: rtl/dwa_pkg.sv
package dwa_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_READ  = 2'd1,
    ST_WRITE = 2'd2
  } dwa_state_e;

  typedef logic [1:0] dwa_size_t;

  localparam dwa_size_t SZ_BAD = 2'd3;

  // beats minus one needed on the narrow side to cover one wide word;
  // also usable as a low-bit mask for the multiple-of-ratio test
  function automatic logic [1:0] beats_m1(dwa_size_t narrow, dwa_size_t wide);
    logic [2:0] span;
    if (narrow < wide) begin
      span = (3'd1 << (wide - narrow)) - 3'd1;
    end else begin
      span = 3'd0;
    end
    return span[1:0];
  endfunction

  function automatic logic [2:0] size_bytes(dwa_size_t sz);
    return 3'd1 << sz;
  endfunction

endpackage

// File: rtl/dwa_addr_gen.sv
module dwa_addr_gen #(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] base,
  input  logic              adv,
  input  logic [2:0]        step,
  output logic [ADDR_W-1:0] addr
);

  logic [ADDR_W-1:0] addr_q;
  logic [ADDR_W-1:0] addr_d;

  always_comb begin
    addr_d = addr_q;
    if (load) begin
      addr_d = base;
    end else if (adv) begin
      addr_d = addr_q + ADDR_W'(step);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
    end else if (load || adv) begin
      addr_q <= addr_d;
    end
  end

  assign addr = addr_q;

  AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !adv) |=> $stable(addr_q)) else $error("address moved without an access"); // R9

endmodule

// File: rtl/dwa_lane_pack.sv
module dwa_lane_pack #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        wr_idx,
  input  logic [1:0]        wr_size,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [1:0]        rd_idx,
  input  logic [1:0]        rd_size,
  output logic [DATA_W-1:0] rd_data
);

  localparam int LANES = DATA_W / 8;
  localparam int OFS_W = $clog2(LANES) + 1;

  logic [OFS_W-1:0]  wr_base;
  logic [OFS_W-1:0]  wr_top;
  logic [OFS_W-1:0]  rd_base;
  logic [DATA_W-1:0] pack_q;
  logic [DATA_W-1:0] rd_shift;
  logic [DATA_W-1:0] rd_mask;

  assign wr_base = OFS_W'(wr_idx) << wr_size;
  assign wr_top  = wr_base + (OFS_W'(1) << wr_size);

  for (genvar b = 0; b < LANES; b++) begin : g_lane
    localparam logic [OFS_W-1:0] LANE = OFS_W'(b);
    logic              hit;
    logic [OFS_W-1:0]  sel;
    logic [DATA_W-1:0] shifted;

    assign hit     = wr_en && (LANE >= wr_base) && (LANE < wr_top);
    assign sel     = LANE - wr_base;
    assign shifted = wr_data >> {sel, 3'b000};

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        pack_q[8*b +: 8] <= 8'h00;
      end else if (hit) begin
        pack_q[8*b +: 8] <= shifted[7:0];
      end
    end
  end

  assign rd_base  = OFS_W'(rd_idx) << rd_size;
  assign rd_shift = pack_q >> {rd_base, 3'b000};
  assign rd_mask  = ~({DATA_W{1'b1}} << (8 << rd_size));
  assign rd_data  = rd_shift & rd_mask;

  AST_LANE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (32'(wr_base) + (32'd1 << wr_size)) <= LANES) else $error("lane write past word top"); // R3

endmodule

// File: rtl/dma_width_adapter.sv
module dma_width_adapter #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              cfg_dir,
  input  logic [1:0]        cfg_psize,
  input  logic [1:0]        cfg_msize,
  input  logic [CNT_W-1:0]  cfg_count,
  input  logic              cfg_pstep4,
  input  logic [ADDR_W-1:0] cfg_paddr,
  input  logic [ADDR_W-1:0] cfg_maddr,
  output logic [ADDR_W-1:0] p_addr,
  output logic              p_rd_valid,
  input  logic              p_rd_ready,
  input  logic [DATA_W-1:0] p_rd_data,
  output logic              p_wr_valid,
  input  logic              p_wr_ready,
  output logic [DATA_W-1:0] p_wr_data,
  output logic [ADDR_W-1:0] m_addr,
  output logic              m_rd_valid,
  input  logic              m_rd_ready,
  input  logic [DATA_W-1:0] m_rd_data,
  output logic              m_wr_valid,
  input  logic              m_wr_ready,
  output logic [DATA_W-1:0] m_wr_data,
  output logic              done,
  output logic              cfg_err
);
  import dwa_pkg::*;

  dwa_state_e       state_q, state_d;
  logic [1:0]       beat_q, beat_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             err_q, err_d;
  logic             done_q, done_d;
  logic             load;

  dwa_size_t        psz_q, msz_q;
  logic             dir_q, step4_q;

  dwa_size_t        src_sz, dst_sz;
  logic [1:0]       src_last, dst_last;
  logic             rd_fire, wr_fire, p_fire, m_fire;
  logic             cfg_bad;
  logic [CNT_W-1:0] cnt_dec, cnt_after;
  logic [DATA_W-1:0] src_data, out_data;
  logic [2:0]       p_step, m_step;

  // start-time legality check on the live configuration
  always_comb begin
    cfg_bad = (cfg_count == '0) || (cfg_psize == SZ_BAD) || (cfg_msize == SZ_BAD);
    if ((cfg_psize != SZ_BAD) && (cfg_msize != SZ_BAD) &&
        ((cfg_count[1:0] & beats_m1(cfg_psize, cfg_msize)) != 2'b00)) begin
      cfg_bad = 1'b1;
    end
  end

  assign src_sz   = dir_q ? msz_q : psz_q;
  assign dst_sz   = dir_q ? psz_q : msz_q;
  assign src_last = beats_m1(src_sz, dst_sz);
  assign dst_last = beats_m1(dst_sz, src_sz);

  assign p_rd_valid = (state_q == ST_READ)  && !dir_q;
  assign m_rd_valid = (state_q == ST_READ)  &&  dir_q;
  assign p_wr_valid = (state_q == ST_WRITE) &&  dir_q;
  assign m_wr_valid = (state_q == ST_WRITE) && !dir_q;

  assign rd_fire = (p_rd_valid && p_rd_ready) || (m_rd_valid && m_rd_ready);
  assign wr_fire = (p_wr_valid && p_wr_ready) || (m_wr_valid && m_wr_ready);
  assign p_fire  = (p_rd_valid && p_rd_ready) || (p_wr_valid && p_wr_ready);
  assign m_fire  = (m_rd_valid && m_rd_ready) || (m_wr_valid && m_wr_ready);

  assign cnt_dec   = cnt_q - CNT_W'(1);
  assign cnt_after = p_fire ? cnt_dec : cnt_q;
  assign src_data  = dir_q ? m_rd_data : p_rd_data;

  // next-state process
  always_comb begin
    state_d = state_q;
    beat_d  = beat_q;
    cnt_d   = cnt_q;
    err_d   = err_q;
    done_d  = 1'b0;
    load    = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start) begin
          if (cfg_bad) begin
            err_d = 1'b1;
          end else begin
            err_d   = 1'b0;
            load    = 1'b1;
            cnt_d   = cfg_count;
            beat_d  = 2'd0;
            state_d = ST_READ;
          end
        end
      end
      ST_READ: begin
        if (rd_fire) begin
          if (p_fire) cnt_d = cnt_dec;
          if (beat_q == src_last) begin
            beat_d  = 2'd0;
            state_d = ST_WRITE;
          end else begin
            beat_d = beat_q + 2'd1;
          end
        end
      end
      ST_WRITE: begin
        if (wr_fire) begin
          if (p_fire) cnt_d = cnt_dec;
          if (beat_q == dst_last) begin
            beat_d = 2'd0;
            if (cnt_after == '0) begin
              state_d = ST_IDLE;
              done_d  = 1'b1;
            end else begin
              state_d = ST_READ;
            end
          end else begin
            beat_d = beat_q + 2'd1;
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // register process
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      beat_q  <= 2'd0;
      cnt_q   <= '0;
      err_q   <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      beat_q  <= beat_d;
      cnt_q   <= cnt_d;
      err_q   <= err_d;
      done_q  <= done_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      psz_q   <= 2'd0;
      msz_q   <= 2'd0;
      dir_q   <= 1'b0;
      step4_q <= 1'b0;
    end else if (load) begin
      psz_q   <= cfg_psize;
      msz_q   <= cfg_msize;
      dir_q   <= cfg_dir;
      step4_q <= cfg_pstep4;
    end
  end

  assign p_step = step4_q ? 3'd4 : size_bytes(psz_q);
  assign m_step = size_bytes(msz_q);

  dwa_addr_gen #(.ADDR_W(ADDR_W)) u_paddr (
    .clk(clk), .rst_n(rst_n), .load(load), .base(cfg_paddr),
    .adv(p_fire), .step(p_step), .addr(p_addr)
  );

  dwa_addr_gen #(.ADDR_W(ADDR_W)) u_maddr (
    .clk(clk), .rst_n(rst_n), .load(load), .base(cfg_maddr),
    .adv(m_fire), .step(m_step), .addr(m_addr)
  );

  dwa_lane_pack #(.DATA_W(DATA_W)) u_pack (
    .clk(clk), .rst_n(rst_n),
    .wr_en(rd_fire), .wr_idx(beat_q), .wr_size(src_sz), .wr_data(src_data),
    .rd_idx(beat_q), .rd_size(dst_sz), .rd_data(out_data)
  );

  assign p_wr_data = out_data;
  assign m_wr_data = out_data;
  assign done      = done_q;
  assign cfg_err   = err_q;

  AST_P_WR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (p_wr_valid && !p_wr_ready) |=> (p_wr_valid && $stable(p_addr) && $stable(p_wr_data))) else $error("p write changed while stalled"); // R9
  AST_M_WR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (m_wr_valid && !m_wr_ready) |=> (m_wr_valid && $stable(m_addr) && $stable(m_wr_data))) else $error("m write changed while stalled"); // R9
  AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    ((p_rd_valid && !p_rd_ready) || (m_rd_valid && !m_rd_ready)) |=> $stable({p_rd_valid, m_rd_valid, p_addr, m_addr})) else $error("read changed while stalled"); // R9
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done) else $error("done longer than one cycle"); // R10
  AST_DONE_AFTER_WR: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past((p_wr_valid && p_wr_ready) || (m_wr_valid && m_wr_ready))) else $error("done without final write"); // R10
  AST_DONE_CNT: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (cnt_q == '0)) else $error("done with items left"); // R2
  AST_ERR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |-> !(p_rd_valid || m_rd_valid || p_wr_valid || m_wr_valid || done)) else $error("activity during config error"); // R8

endmodule

// File: tb/tb_dma_width_adapter.sv
module tb_dma_width_adapter;

  localparam int CLK_PERIOD = 10;
  localparam int MAXN = 256;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        start;
  logic        cfg_dir;
  logic [1:0]  cfg_psize, cfg_msize;
  logic [15:0] cfg_count;
  logic        cfg_pstep4;
  logic [31:0] cfg_paddr, cfg_maddr;
  logic [31:0] p_addr, m_addr;
  logic        p_rd_valid, p_rd_ready, p_wr_valid, p_wr_ready;
  logic        m_rd_valid, m_rd_ready, m_wr_valid, m_wr_ready;
  logic [31:0] p_rd_data, p_wr_data, m_rd_data, m_wr_data;
  logic        done, cfg_err;

  int checks = 0;
  int failures = 0;

  logic [31:0] e_src_a [MAXN];
  logic [31:0] e_dst_a [MAXN];
  logic [31:0] e_dst_d [MAXN];
  logic [7:0]  bstream [4*MAXN];
  int n_src, n_dst;

  always #(CLK_PERIOD/2) clk = ~clk;

  dma_width_adapter dut (
    .clk(clk), .rst_n(rst_n), .start(start), .cfg_dir(cfg_dir),
    .cfg_psize(cfg_psize), .cfg_msize(cfg_msize), .cfg_count(cfg_count),
    .cfg_pstep4(cfg_pstep4), .cfg_paddr(cfg_paddr), .cfg_maddr(cfg_maddr),
    .p_addr(p_addr), .p_rd_valid(p_rd_valid), .p_rd_ready(p_rd_ready), .p_rd_data(p_rd_data),
    .p_wr_valid(p_wr_valid), .p_wr_ready(p_wr_ready), .p_wr_data(p_wr_data),
    .m_addr(m_addr), .m_rd_valid(m_rd_valid), .m_rd_ready(m_rd_ready), .m_rd_data(m_rd_data),
    .m_wr_valid(m_wr_valid), .m_wr_ready(m_wr_ready), .m_wr_data(m_wr_data),
    .done(done), .cfg_err(cfg_err)
  );

  function automatic logic [31:0] pat(logic [31:0] a);
    return (a * 32'h9E37_79B1) ^ 32'hC3A5_5A3C;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic summary_and_end();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  // expected address/data lists from the requirements (R2..R7)
  task automatic build(input bit dir, input int psz, input int msz, input bit st4,
                       input int cnt, input logic [31:0] pa, input logic [31:0] ma);
    int pb = 1 << psz;
    int mb = 1 << msz;
    int pst = st4 ? 4 : pb;
    int n_m = cnt * pb / mb;
    int sb = dir ? mb : pb;
    int db = dir ? pb : mb;
    n_src = dir ? n_m : cnt;
    n_dst = dir ? cnt : n_m;
    for (int i = 0; i < n_src; i++) begin
      logic [31:0] a = dir ? ma + 32'(i * mb) : pa + 32'(i * pst);
      logic [31:0] d = pat(a);
      e_src_a[i] = a;
      for (int k = 0; k < sb; k++) bstream[i*sb + k] = d[8*k +: 8];
    end
    for (int j = 0; j < n_dst; j++) begin
      logic [31:0] w = '0;
      e_dst_a[j] = dir ? pa + 32'(j * pst) : ma + 32'(j * mb);
      for (int k = 0; k < db; k++) w[8*k +: 8] = bstream[j*db + k];
      e_dst_d[j] = w;
    end
  endtask

  task automatic pulse_start(input bit dir, input int psz, input int msz, input bit st4,
                             input int cnt, input logic [31:0] pa, input logic [31:0] ma);
    @(negedge clk);
    cfg_dir = dir; cfg_psize = 2'(psz); cfg_msize = 2'(msz); cfg_pstep4 = st4;
    cfg_count = 16'(cnt); cfg_paddr = pa; cfg_maddr = ma; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic run_xfer(input bit dir, input int psz, input int msz, input bit st4,
                          input int cnt, input logic [31:0] pa, input logic [31:0] ma,
                          input int rdy_pct);
    int si = 0, di = 0, cyc = 0;
    bit last_seen = 0, early_done = 0, wrong_side = 0;
    bit stall = 0, stall_bad = 0;
    logic [31:0] st_a = '0, st_d = '0;
    int bad_sa = 0, bad_da = 0, bad_dd = 0;
    logic [31:0] fa_act = '0, fa_exp = '0, fd_act = '0, fd_exp = '0;
    string dtag = dir ? "R4" : "R3";
    string ptag = st4 ? "R6" : "R5";
    build(dir, psz, msz, st4, cnt, pa, ma);
    pulse_start(dir, psz, msz, st4, cnt, pa, ma);
    check(cfg_err == 1'b0, "R8", "cfg_err cleared by legal start", 32'(cfg_err), 0);
    forever begin
      logic sv, dv, rs, rd;
      logic [31:0] sa, da, dd;
      if (last_seen) begin
        check(done == 1'b1, "R10", "done after final write", 32'(done), 1);
        break;
      end
      if (done) early_done = 1;
      sv = dir ? m_rd_valid : p_rd_valid;
      dv = dir ? p_wr_valid : m_wr_valid;
      sa = dir ? m_addr : p_addr;
      da = dir ? p_addr : m_addr;
      dd = dir ? p_wr_data : m_wr_data;
      if ((dir ? (p_rd_valid || m_wr_valid) : (m_rd_valid || p_wr_valid))) wrong_side = 1;
      if (stall && !((sv || dv) && (sv ? sa : da) == st_a && (sv ? 32'h0 : dd) == st_d)) stall_bad = 1;
      rs = sv && (($urandom % 100) < rdy_pct);
      rd = dv && (($urandom % 100) < rdy_pct);
      if (sv) begin
        if (si >= n_src || sa !== e_src_a[si]) begin
          bad_sa++; fa_act = sa; fa_exp = (si < n_src) ? e_src_a[si] : 32'hx;
        end
        if (rs) si++;
      end
      if (dv) begin
        if (di >= n_dst || da !== e_dst_a[di]) begin
          bad_da++; fa_act = da; fa_exp = (di < n_dst) ? e_dst_a[di] : 32'hx;
        end
        if (di < n_dst && dd !== e_dst_d[di]) begin
          bad_dd++; fd_act = dd; fd_exp = e_dst_d[di];
        end
        if (rd) begin
          di++;
          if (di == n_dst) last_seen = 1;
        end
      end
      stall = (sv && !rs) || (dv && !rd);
      st_a = sv ? sa : da;
      st_d = sv ? 32'h0 : dd;
      if (dir) begin m_rd_ready = rs; m_rd_data = pat(sa); p_wr_ready = rd; end
      else     begin p_rd_ready = rs; p_rd_data = pat(sa); m_wr_ready = rd; end
      cyc++;
      if (cyc > 5000) begin
        check(1'b0, "R10", "run timed out", 32'(di), 32'(n_dst));
        break;
      end
      @(negedge clk);
    end
    p_rd_ready = 0; m_rd_ready = 0; p_wr_ready = 0; m_wr_ready = 0;
    check(bad_sa == 0 && bad_da == 0, dir ? "R7" : ptag, "source/dest address sequence", fa_act, fa_exp);
    check(bad_dd == 0, dtag, "destination data lanes", fd_act, fd_exp);
    check(!wrong_side && si == n_src, "R2", "source access count", 32'(si), 32'(n_src));
    check(!early_done, "R10", "no early done", 32'(early_done), 0);
    check(!stall_bad, "R9", "stalled request held", 32'(stall_bad), 0);
    @(negedge clk);
    check(done == 1'b0, "R10", "done is a single cycle", 32'(done), 0);
    check(!(p_rd_valid || m_rd_valid || p_wr_valid || m_wr_valid), "R2", "idle after run",
          32'({p_rd_valid, m_rd_valid, p_wr_valid, m_wr_valid}), 0);
  endtask

  task automatic run_err(input bit dir, input int psz, input int msz, input int cnt, input string why);
    bit busy = 0;
    pulse_start(dir, psz, msz, 1'b0, cnt, 32'h100, 32'h2000);
    p_rd_ready = 1; m_rd_ready = 1; p_wr_ready = 1; m_wr_ready = 1;
    for (int i = 0; i < 8; i++) begin
      if (p_rd_valid || m_rd_valid || p_wr_valid || m_wr_valid || done) busy = 1;
      @(negedge clk);
    end
    p_rd_ready = 0; m_rd_ready = 0; p_wr_ready = 0; m_wr_ready = 0;
    check(cfg_err == 1'b1, "R8", why, 32'(cfg_err), 1);
    check(!busy, "R8", {why, " issues nothing"}, 32'(busy), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    check(1'b0, "R10", "watchdog expired", 0, 0);
    summary_and_end();
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 0; start = 0; cfg_dir = 0; cfg_psize = 0; cfg_msize = 0; cfg_count = 0;
    cfg_pstep4 = 0; cfg_paddr = 0; cfg_maddr = 0;
    p_rd_ready = 0; m_rd_ready = 0; p_wr_ready = 0; m_wr_ready = 0;
    p_rd_data = 0; m_rd_data = 0;
    repeat (3) @(negedge clk);
    check(!(done || cfg_err || p_rd_valid || m_rd_valid || p_wr_valid || m_wr_valid), "R11",
          "outputs cleared in reset", 32'({done, cfg_err, p_rd_valid, m_rd_valid, p_wr_valid, m_wr_valid}), 0);
    rst_n = 1;
    @(negedge clk);
    check(!(done || cfg_err), "R11", "outputs quiet after reset", 32'({done, cfg_err}), 0);

    // directed corner cases
    run_xfer(0, 0, 2, 0, 4, 32'h40, 32'h1000, 100);   // R3 byte->word packing
    run_xfer(1, 0, 2, 0, 8, 32'h80, 32'h1100, 100);   // R4 word->byte unpacking
    run_xfer(0, 1, 2, 0, 6, 32'h10, 32'h1200, 60);    // R3 half->word
    run_xfer(1, 1, 2, 0, 4, 32'h20, 32'h1300, 60);    // R4 word->half
    run_xfer(0, 2, 0, 0, 3, 32'h30, 32'h1400, 50);    // R4 peripheral wider than memory
    run_xfer(0, 0, 0, 0, 5, 32'h50, 32'h1500, 70);    // R1 equal widths
    run_xfer(0, 0, 2, 1, 8, 32'h00, 32'h1600, 80);    // R6 4-byte step, byte items
    run_xfer(1, 1, 0, 1, 3, 32'h00, 32'h1700, 40);    // R6 4-byte step, halfword items

    // illegal configurations and recovery
    run_err(0, 0, 2, 6, "count not multiple of 4");
    run_err(1, 1, 2, 3, "count not multiple of 2");
    run_err(0, 1, 1, 0, "zero count");
    run_err(0, 3, 0, 4, "size code 3");
    run_xfer(0, 1, 1, 0, 2, 32'h60, 32'h1800, 100);   // R8 recovery

    // constrained random runs across all nine width pairs (R1)
    for (int t = 0; t < 30; t++) begin
      int ps = $urandom % 3;
      int ms = $urandom % 3;
      int ratio = (ps < ms) ? (1 << (ms - ps)) : 1;
      int cnt = ratio * (1 + ($urandom % 8));
      run_xfer(1'($urandom % 2), ps, ms, 1'($urandom % 2), cnt,
               32'($urandom % 256) << 2, 32'h4000 + (32'($urandom % 256) << 2), 30 + ($urandom % 71));
    end
    summary_and_end();
  end

endmodule